// File: doc/BRIEF.md
# Processor Mode and Privilege Controller

This block keeps the execution context of a small microcontroller core: whether the core runs ordinary code (thread mode) or services an exception (handler mode), the privilege the running code really has, which stack pointer is in use, and the number of the exception being serviced. The core's front end offers exception requests, each with a number, a priority and a flag for fixed-priority faults. It also signals exception returns and issues writes to three small system registers: control, global mask and priority threshold.

Configurable-priority requests pass through a filter before they are accepted. The global mask bit stops all of them. A nonzero threshold stops any request whose priority value is at or above it, because lower values are more urgent. Handler mode always runs privileged on the main stack. Code in unprivileged thread mode cannot write any of the system registers, so the only way back to privilege is through an exception whose handler rewrites the control register. Exceptions do not nest: one level of handler is tracked.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: One clock after a cycle with `rst` high, the outputs show thread mode (`handler_mode`=0), `irq_status`=0, `priv_eff`=1, `sp_proc`=0 and `exc_taken`=0. The mask and the threshold are clear.
- R2: While `handler_mode` is 1, `priv_eff` is 1 whatever the control privilege bit holds.
- R3: While `handler_mode` is 0, `priv_eff` is the inverse of control bit 0 (1 in that bit means unprivileged).
- R4: An accepted request in thread mode sets `handler_mode` on the next clock and pulses `exc_taken` high for that one cycle. `exc_ret` in handler mode returns to thread mode on the next clock. Requests in handler mode and `exc_ret` in thread mode have no effect.
- R5: `irq_status` is 0 in thread mode. In handler mode it holds the accepted exception number, zero-extended, and keeps it until the return.
- R6: A write made while in thread mode with `priv_eff`=0 changes no register. Privilege comes back only through an exception.
- R7: In thread mode `sp_proc` equals control bit 1 (1 selects the process stack).
- R8: In handler mode `sp_proc` is 0 (main stack).
- R9: While the mask bit is 1, requests with `exc_fixed`=0 are refused. Requests with `exc_fixed`=1 ignore both the mask and the threshold.
- R10: With a nonzero threshold, a request with `exc_fixed`=0 is refused when `exc_prio` >= threshold. A threshold of 0 refuses nothing.
- R11: A request with `exc_num`=0 is never accepted.
- R12: A privileged write (handler mode, or thread mode with `priv_eff`=1) takes effect at the next clock. `wr_sel`=0 writes control bits [1:0]. `wr_sel`=1 writes the mask from `wr_data[0]`. `wr_sel`=2 writes the threshold from the low PRIO_W bits. `wr_sel`=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception or interrupt request, sampled each clock |
| exc_num | input | EXC_W | Number of the requested exception |
| exc_prio | input | PRIO_W | Priority of the request; a lower value is more urgent |
| exc_fixed | input | 1 | Request has fixed priority and bypasses the mask and the threshold |
| exc_ret | input | 1 | Exception return event |
| wr_en | input | 1 | System register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 mask, 2 threshold, 3 none |
| wr_data | input | DATA_W | Write data |
| handler_mode | output | 1 | 1 in handler mode, 0 in thread mode |
| priv_eff | output | 1 | Effective privilege, 1 = privileged |
| sp_proc | output | 1 | Stack select, 1 = process stack |
| irq_status | output | ST_W | Active exception number, 0 in thread mode |
| exc_taken | output | 1 | One-cycle pulse in the first cycle of handler mode |

## Verification
The assertions assume that `rst` is held for at least one clock at start-up. They also take the inputs to be stable across each rising edge, and take a return in handler mode to reach the block as a single `exc_ret` cycle. They place no limit on how requests, returns and writes combine in one cycle, because the block defines the outcome of every combination. The stimulus changes inputs only on falling edges. It mixes directed sequences with random cycles, and in those random cycles requests, returns and writes of every select overlap freely, including requests numbered 0.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } wsel_e;

  // Control register layout: bit 1 process stack, bit 0 unprivileged
  typedef struct packed {
    logic sp_proc;
    logic npriv;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pmc_irq_gate.sv
module pmc_irq_gate #(
  parameter int EXC_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic              req,
  input  logic              fixed,
  input  logic              in_thread,
  input  logic              mask,
  input  logic [EXC_W-1:0]  num,
  input  logic [PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0] thr,
  output logic              accept
);
  logic thr_on;
  logic thr_block;
  logic filtered;

  always_comb begin
    thr_on    = |thr;
    thr_block = thr_on && (prio >= thr);
    filtered  = mask || thr_block;
    accept    = req && in_thread && (|num) && (fixed || !filtered);
  end
endmodule

// File: rtl/pmc_sysregs.sv
module pmc_sysregs
  import pmc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              privileged,
  output ctrl_t             ctrl,
  output logic              mask,
  output logic [PRIO_W-1:0] thr
);
  logic wr_ok;
  wsel_e sel;

  always_comb begin
    wr_ok = wr_en && privileged;
    sel   = wsel_e'(wr_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mask <= 1'b0;
      thr  <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        SEL_MASK: mask <= wr_data[0];
        SEL_THR:  thr  <= wr_data[PRIO_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int EXC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [EXC_W-1:0] exc_num,
  input  logic             exc_ret,
  output mode_e            mode,
  output logic [EXC_W-1:0] act_num,
  output logic             taken
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= MODE_THREAD;
      act_num <= '0;
      taken   <= 1'b0;
    end else begin
      taken <= accept;
      case (mode)
        MODE_THREAD: if (accept) begin
          mode    <= MODE_HANDLER;
          act_num <= exc_num;
        end
        MODE_HANDLER: if (exc_ret) begin
          mode    <= MODE_THREAD;
          act_num <= '0;
        end
        default: mode <= MODE_THREAD;
      endcase
    end
  end
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int EXC_W  = 8,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8,
  parameter int ST_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_req,
  input  logic [EXC_W-1:0]  exc_num,
  input  logic [PRIO_W-1:0] exc_prio,
  input  logic              exc_fixed,
  input  logic              exc_ret,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              handler_mode,
  output logic              priv_eff,
  output logic              sp_proc,
  output logic [ST_W-1:0]   irq_status,
  output logic              exc_taken
);
  localparam int PAD_W = ST_W - EXC_W;

  mode_e             mode;
  logic [EXC_W-1:0]  act_num;
  ctrl_t             ctrl;
  logic              mask;
  logic [PRIO_W-1:0] thr;
  logic              in_handler;
  logic              accept;

  assign in_handler = (mode == MODE_HANDLER);

  pmc_irq_gate #(.EXC_W(EXC_W), .PRIO_W(PRIO_W)) gate_i (
    .req       (exc_req),
    .fixed     (exc_fixed),
    .in_thread (!in_handler),
    .mask      (mask),
    .num       (exc_num),
    .prio      (exc_prio),
    .thr       (thr),
    .accept    (accept)
  );

  pmc_sysregs #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .privileged (priv_eff),
    .ctrl       (ctrl),
    .mask       (mask),
    .thr        (thr)
  );

  pmc_mode_fsm #(.EXC_W(EXC_W)) fsm_i (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .exc_num (exc_num),
    .exc_ret (exc_ret),
    .mode    (mode),
    .act_num (act_num),
    .taken   (exc_taken)
  );

  always_comb begin
    handler_mode = in_handler;
    priv_eff     = in_handler || !ctrl.npriv;
    sp_proc      = !in_handler && ctrl.sp_proc;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign irq_status = {{PAD_W{1'b0}}, act_num};
    end else begin : g_trunc
      assign irq_status = act_num[ST_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pmc_mode_ctrl_chk.sv
module pmc_mode_ctrl_chk #(
  parameter int EXC_W  = 8,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8,
  parameter int ST_W   = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_req,
  input logic [EXC_W-1:0]  exc_num,
  input logic              exc_ret,
  input logic              wr_en,
  input logic              handler_mode,
  input logic              priv_eff,
  input logic              sp_proc,
  input logic [ST_W-1:0]   irq_status,
  input logic              exc_taken
);
  assert_handler_priv_R2: assert property (@(posedge clk) disable iff (rst)
    handler_mode |-> priv_eff);

  assert_handler_main_stack_R8: assert property (@(posedge clk) disable iff (rst)
    handler_mode |-> !sp_proc);

  assert_thread_status_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !handler_mode |-> (irq_status == '0));

  assert_status_held_R5: assert property (@(posedge clk) disable iff (rst)
    (handler_mode && !exc_ret) |=> (handler_mode && $stable(irq_status)));

  assert_taken_enters_handler_R4: assert property (@(posedge clk) disable iff (rst)
    exc_taken |-> (handler_mode && irq_status != '0));

  assert_return_to_thread_R4: assert property (@(posedge clk) disable iff (rst)
    (handler_mode && exc_ret) |=> !handler_mode);

  assert_no_self_raise_R6: assert property (@(posedge clk) disable iff (rst)
    (!handler_mode && !priv_eff) |=> (handler_mode || !priv_eff));

  assert_taken_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    exc_taken |=> !exc_taken);
endmodule

bind pmc_mode_ctrl pmc_mode_ctrl_chk #(
  .EXC_W(EXC_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ST_W(ST_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .exc_req      (exc_req),
  .exc_num      (exc_num),
  .exc_ret      (exc_ret),
  .wr_en        (wr_en),
  .handler_mode (handler_mode),
  .priv_eff     (priv_eff),
  .sp_proc      (sp_proc),
  .irq_status   (irq_status),
  .exc_taken    (exc_taken)
);

// File: tb/pmc_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pmc_mode_ctrl_tb_top;
  localparam int EXC_W  = 8;
  localparam int PRIO_W = 4;
  localparam int DATA_W = 8;
  localparam int ST_W   = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              exc_req = 1'b0;
  logic [EXC_W-1:0]  exc_num = '0;
  logic [PRIO_W-1:0] exc_prio = '0;
  logic              exc_fixed = 1'b0;
  logic              exc_ret = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_sel = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              handler_mode;
  logic              priv_eff;
  logic              sp_proc;
  logic [ST_W-1:0]   irq_status;
  logic              exc_taken;

  always #2.5 clk = ~clk;

  pmc_mode_ctrl #(.EXC_W(EXC_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ST_W(ST_W)) dut_i (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_num(exc_num), .exc_prio(exc_prio),
    .exc_fixed(exc_fixed), .exc_ret(exc_ret), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .handler_mode(handler_mode), .priv_eff(priv_eff),
    .sp_proc(sp_proc), .irq_status(irq_status), .exc_taken(exc_taken)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit armed = 0;
  bit fresh = 0;

  // Behavioural reference state
  int m_hand = 0, m_num = 0, m_npriv = 0, m_sp = 0, m_mask = 0, m_thr = 0, m_taken = 0;

  always @(posedge clk) begin
    int priv, acc, blk;
    if (rst) begin
      m_hand = 0; m_num = 0; m_npriv = 0; m_sp = 0; m_mask = 0; m_thr = 0; m_taken = 0;
      armed = 1; fresh = 1;
    end else begin
      fresh = 0;
      priv = (m_hand != 0 || m_npriv == 0) ? 1 : 0;
      blk  = (m_mask != 0 || (m_thr != 0 && int'(exc_prio) >= m_thr)) ? 1 : 0;
      acc  = (exc_req && m_hand == 0 && exc_num != 0 && (exc_fixed || blk == 0)) ? 1 : 0;
      if (wr_en && priv != 0) begin
        if (wr_sel == 2'd0) begin m_npriv = int'(wr_data[0]); m_sp = int'(wr_data[1]); end
        else if (wr_sel == 2'd1) m_mask = int'(wr_data[0]);
        else if (wr_sel == 2'd2) m_thr = int'(wr_data[PRIO_W-1:0]);
      end
      m_taken = acc;
      if (m_hand != 0) begin
        if (exc_ret) begin m_hand = 0; m_num = 0; end
      end else if (acc != 0) begin
        m_hand = 1; m_num = int'(exc_num);
      end
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      if (fresh) begin
        // R1 reset state
        cmp("R1", "handler_mode", 32'(handler_mode), 0);
        cmp("R1", "priv_eff", 32'(priv_eff), 1);
        cmp("R1", "sp_proc", 32'(sp_proc), 0);
        cmp("R1", "irq_status", irq_status, 0);
        cmp("R1", "exc_taken", 32'(exc_taken), 0);
      end else begin
        cmp("R4 R9 R10 R11", "handler_mode", 32'(handler_mode), 32'(m_hand));
        cmp("R4", "exc_taken", 32'(exc_taken), 32'(m_taken));
        cmp(m_hand != 0 ? "R2" : "R3 R6 R12", "priv_eff", 32'(priv_eff),
            32'((m_hand != 0 || m_npriv == 0) ? 1 : 0));
        cmp(m_hand != 0 ? "R8" : "R7", "sp_proc", 32'(sp_proc),
            32'((m_hand == 0 && m_sp != 0) ? 1 : 0));
        cmp("R5", "irq_status", irq_status, 32'(m_hand != 0 ? m_num : 0));
      end
    end
  end

  task automatic step(input bit rq, input int num, input int pr, input bit fx,
                      input bit rt, input bit we, input int sel, input int dat);
    @(negedge clk);
    exc_req = rq; exc_num = EXC_W'(num); exc_prio = PRIO_W'(pr); exc_fixed = fx;
    exc_ret = rt; wr_en = we; wr_sel = 2'(sel); wr_data = DATA_W'(dat);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R9: mask blocks configurable requests, fixed ones pass
    step(0, 0, 0, 0, 0, 1, 1, 1);
    step(1, 5, 2, 0, 0, 0, 0, 0); idle();
    step(1, 6, 2, 1, 0, 0, 0, 0); idle();
    step(0, 0, 0, 0, 1, 0, 0, 0); idle();
    step(0, 0, 0, 0, 0, 1, 1, 0);
    // R10: threshold 3 blocks prio 3 and 4, passes prio 2
    step(0, 0, 0, 0, 0, 1, 2, 3);
    step(1, 7, 3, 0, 0, 0, 0, 0);
    step(1, 7, 4, 0, 0, 0, 0, 0);
    step(1, 8, 2, 0, 0, 0, 0, 0); idle();
    // R4: request in handler ignored, return in thread ignored
    step(1, 9, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 0, 0); idle();
    step(0, 0, 0, 0, 0, 1, 2, 0);
    step(1, 15, 15, 0, 0, 0, 0, 0); idle();
    step(0, 0, 0, 0, 1, 0, 0, 0);
    // R11: number zero refused
    step(1, 0, 0, 1, 0, 0, 0, 0); idle();
    // R7 then R8: process stack in thread, main in handler
    step(0, 0, 0, 0, 0, 1, 0, 2); idle();
    step(1, 200, 1, 0, 0, 0, 0, 0); idle();
    // R12: handler writes control to unprivileged, process stack; R3 after return
    step(0, 0, 0, 0, 0, 1, 0, 3);
    step(0, 0, 0, 0, 1, 0, 0, 0); idle();
    // R6: unprivileged writes ignored
    step(0, 0, 0, 0, 0, 1, 0, 0); idle();
    step(0, 0, 0, 0, 0, 1, 1, 1); idle();
    step(1, 33, 9, 0, 0, 0, 0, 0); idle();
    // regain privilege in handler, select 3 writes nothing
    step(0, 0, 0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 3, 255);
    step(0, 0, 0, 0, 1, 0, 0, 0); idle();
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      step($urandom_range(0, 3) == 0, int'($urandom_range(0, 20)), int'($urandom_range(0, 15)),
           $urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0,
           int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
    end
    idle(); idle();
    done = 1;
    summary();
    $finish;
  end
endmodule